// File: doc/BRIEF.md
# Acquisition Card Control Register Interface

This block is the bus-slave register front end of an eight-channel analog acquisition card whose input stage has programmable gain. A host reaches it with byte reads and writes. Two byte locations, at fixed offsets from a base address, are decoded. The control location holds the analog multiplexer channel, an interrupt enable and four general-purpose digital outputs. The gain location holds a four-bit range code that is driven to the gain stage. The block does not interpret the range code.

The block also watches an external interrupt line. The line is synchronised and its rising edges are detected. Every edge sets a sticky status flag. An edge that arrives while interrupts are enabled raises the bus interrupt request and clears the enable. Further interrupts therefore need the service routine to write the enable again as its last step. That control write also drops the request.

Top module: `daq_ctrl_regs`

## Requirements
- R1: After reset, chan_o, range_o, dout_o and irq_o are 0, and the interrupt enable and status flag are 0.
- R2: A write to BASE_ADDR+2 loads chan_o from wdata_i[2:0], the interrupt enable from wdata_i[3], and dout_o[k] from wdata_i[4+k]. The channel is reloaded on every such write, including when the value is unchanged.
- R3: A write to BASE_ADDR+3 loads range_o from wdata_i[3:0]. wdata_i[7:4] have no effect.
- R4: ext_irq_i passes through a two-flop synchroniser. A rising edge sets the status flag on the third rising clock edge at which ext_irq_i is sampled high after being low.
- R5: If the enable is 1 when an edge is detected, irq_o rises on that same clock edge and the enable is cleared. If the enable is 0, irq_o stays low.
- R6: Once high, irq_o stays high until the next write to BASE_ADDR+2, which clears it. When a control write and a detected edge fall in the same cycle, the write decides the enable and irq_o.
- R7: A read of BASE_ADDR+2 returns {3'b000, status, enable, chan} on rdata_o, combinationally. It clears the status flag at the next clock edge, unless an edge sets the flag in that same cycle.
- R8: A read of BASE_ADDR+3 returns {1'b0, chan, range} on rdata_o.
- R9: Writes to any other address change no output or register. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| ext_irq_i | input | 1 | Asynchronous external interrupt line |
| irq_o | output | 1 | Bus interrupt request |
| chan_o | output | 3 | Multiplexer channel |
| dout_o | output | 4 | Digital output lines |
| range_o | output | 4 | Gain range code |

## Verification
The assertions assume that wr_i and rd_i are never high together. They also assume that ext_irq_i, although asynchronous in use, is held for at least one clock at each level, so that the synchroniser sees every edge. The random stimulus issues at most one bus operation per cycle. It draws addresses around the two decoded offsets so that writes to other addresses also occur. It toggles ext_irq_i only at negative clock edges, with a bias that keeps levels held for several cycles. Directed cases then place a control write on the same cycle as a detected edge, and a status-clearing read on the same cycle as an edge.

// File: rtl/daq_regs_pkg.sv
package daq_regs_pkg;
  localparam int DATA_W   = 8;
  localparam int CHAN_W   = 3;
  localparam int DOUT_W   = 4;
  localparam int RANGE_W  = 4;
  localparam int CTRL_OFF = 2;
  localparam int GAIN_OFF = 3;
  // control byte field positions
  localparam int EN_BIT   = CHAN_W;
  localparam int DOUT_LSB = CHAN_W + 1;
  localparam int STAT_BIT = CHAN_W + 1;
endpackage

// File: rtl/daq_sync.sv
module daq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end
  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/daq_irq_unit.sv
module daq_irq_unit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic ctrl_wr_i,
  input  logic wr_en_i,
  input  logic stat_clr_i,
  output logic en_o,
  output logic stat_o,
  output logic irq_o
);
  logic prev_q, edge_det;
  assign edge_det = sync_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      en_o   <= 1'b0;
      stat_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      prev_q <= sync_i;
      // set beats read-clear
      if (edge_det)        stat_o <= 1'b1;
      else if (stat_clr_i) stat_o <= 1'b0;
      // bus write beats a coincident edge
      if (ctrl_wr_i) begin
        en_o  <= wr_en_i;
        irq_o <= 1'b0;
      end else if (edge_det && en_o) begin
        en_o  <= 1'b0;
        irq_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/daq_reg_bank.sv
module daq_reg_bank
  import daq_regs_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_wr_i,
  input  logic               gain_wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [CHAN_W-1:0]  chan_o,
  output logic [DOUT_W-1:0]  dout_o,
  output logic [RANGE_W-1:0] range_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_o  <= '0;
      dout_o  <= '0;
      range_o <= '0;
    end else begin
      if (ctrl_wr_i) begin
        chan_o <= wdata_i[CHAN_W-1:0];
        dout_o <= wdata_i[DOUT_LSB +: DOUT_W];
      end
      if (gain_wr_i) range_o <= wdata_i[RANGE_W-1:0];
    end
  end
endmodule

// File: rtl/daq_ctrl_regs.sv
module daq_ctrl_regs
  import daq_regs_pkg::*;
#(
  parameter int              ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300,
  parameter int              SYNC_STG  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              ext_irq_i,
  output logic              irq_o,
  output logic [2:0]        chan_o,
  output logic [3:0]        dout_o,
  output logic [3:0]        range_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = BASE_ADDR + ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] GAIN_ADDR = BASE_ADDR + ADDR_W'(GAIN_OFF);

  logic hit_ctrl, hit_gain, ctrl_wr, gain_wr, ctrl_rd;
  logic irq_sync, en_q, stat_q;

  assign hit_ctrl = (addr_i == CTRL_ADDR);
  assign hit_gain = (addr_i == GAIN_ADDR);
  assign ctrl_wr  = wr_i & hit_ctrl;
  assign gain_wr  = wr_i & hit_gain;
  assign ctrl_rd  = rd_i & hit_ctrl;

  daq_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(ext_irq_i), .q_o(irq_sync)
  );

  daq_irq_unit u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (irq_sync),
    .ctrl_wr_i (ctrl_wr),
    .wr_en_i   (wdata_i[EN_BIT]),
    .stat_clr_i(ctrl_rd),
    .en_o      (en_q),
    .stat_o    (stat_q),
    .irq_o     (irq_o)
  );

  daq_reg_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_wr_i(ctrl_wr),
    .gain_wr_i(gain_wr),
    .wdata_i  (wdata_i),
    .chan_o   (chan_o),
    .dout_o   (dout_o),
    .range_o  (range_o)
  );

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl)      rdata_o = {3'b000, stat_q, en_q, chan_o};
    else if (hit_gain) rdata_o = {1'b0, chan_o, range_o};
  end
endmodule

// File: rtl/daq_ctrl_regs_chk.sv
module daq_ctrl_regs_chk #(
  parameter int                ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [7:0]        wdata_i,
  input logic              irq_o,
  input logic [2:0]        chan_o,
  input logic [3:0]        range_o,
  input logic              en_q,
  input logic              stat_q
);
  logic ctrl_wr, gain_wr;
  assign ctrl_wr = wr_i && (addr_i == BASE_ADDR + ADDR_W'(2));
  assign gain_wr = wr_i && (addr_i == BASE_ADDR + ADDR_W'(3));

  a_r2_chan_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> chan_o == $past(wdata_i[2:0]));
  a_r3_range_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_wr |=> range_o == $past(wdata_i[3:0]));
  a_r9_range_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gain_wr |=> $stable(range_o));
  a_r4_stat_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> stat_q);
  a_r5_en_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !en_q);
  a_r6_irq_drop_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(ctrl_wr));
endmodule

bind daq_ctrl_regs daq_ctrl_regs_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
  .irq_o(irq_o), .chan_o(chan_o), .range_o(range_o), .en_q(en_q), .stat_q(stat_q)
);

// File: tb/tb_daq_ctrl_regs.sv
`timescale 1ns/1ps
module tb_daq_ctrl_regs;
  localparam int AW = 10;
  localparam logic [AW-1:0] BASE = 10'h300;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic wr = 0, rd = 0, ext = 0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  logic [2:0] chan;
  logic [3:0] dout, rng;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic m_s1, m_s2, m_s3, m_en, m_stat, m_irq;
  logic [2:0] m_chan;
  logic [3:0] m_dout, m_rng;

  always #10 clk = ~clk;

  daq_ctrl_regs #(.ADDR_W(AW), .BASE_ADDR(BASE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .ext_irq_i(ext), .irq_o(irq),
    .chan_o(chan), .dout_o(dout), .range_o(rng)
  );

  function automatic logic [7:0] exp_rdata(logic [AW-1:0] a);
    if (a == BASE + 2) return {3'b000, m_stat, m_en, m_chan};
    if (a == BASE + 3) return {1'b0, m_chan, m_rng};
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    {m_s1, m_s2, m_s3, m_en, m_stat, m_irq} = '0;
    m_chan = '0; m_dout = '0; m_rng = '0;
  endtask

  // one bus cycle: drive at negedge, check, advance model and clock
  task automatic cyc(logic w, logic r, logic [AW-1:0] a, logic [7:0] d, logic e, string tag);
    logic edge_d, cw, gw, cr;
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d; ext = e;
    #1;
    chk({tag, " R1/R2 chan"}, chan, m_chan);
    chk({tag, " R2 dout"}, dout, m_dout);
    chk({tag, " R3 range"}, rng, m_rng);
    chk({tag, " R5/R6 irq"}, irq, m_irq);
    if (r) chk({tag, " R7/R8/R9 rdata"}, rdata, exp_rdata(a));
    edge_d = m_s2 & ~m_s3;
    cw = w && a == BASE + 2;
    gw = w && a == BASE + 3;
    cr = r && a == BASE + 2;
    if (edge_d) m_stat = 1; else if (cr) m_stat = 0;
    if (cw) begin m_en = d[3]; m_irq = 0; end
    else if (edge_d && m_en) begin m_en = 0; m_irq = 1; end
    if (cw) begin m_chan = d[2:0]; m_dout = d[7:4]; end
    if (gw) m_rng = d[3:0];
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = e;
    @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    logic e;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    cyc(0, 1, BASE + 2, 0, 0, "R1 rst ctrl");
    cyc(0, 1, BASE + 3, 0, 0, "R1 rst gain");
    // R2 writes, same value reload
    cyc(1, 0, BASE + 2, 8'hA5, 0, "R2 wr");
    cyc(1, 0, BASE + 2, 8'hA5, 0, "R2 rewr");
    cyc(0, 1, BASE + 2, 0, 0, "R2 rd");
    // R3 upper bits ignored, R8 merge
    cyc(1, 0, BASE + 3, 8'hF6, 0, "R3 wr");
    cyc(0, 1, BASE + 3, 0, 0, "R8 rd");
    // R9 other address
    cyc(1, 0, BASE + 1, 8'hFF, 0, "R9 wr");
    cyc(1, 0, BASE + 4, 8'hFF, 0, "R9 wr");
    cyc(0, 1, BASE + 4, 0, 0, "R9 rd");
    // R4/R5 enabled edge
    cyc(1, 0, BASE + 2, 8'h08, 0, "R5 en");
    cyc(0, 0, 0, 0, 1, "R4 e1");
    cyc(0, 0, 0, 0, 1, "R4 e2");
    cyc(0, 0, 0, 0, 1, "R4 e3");
    cyc(0, 0, 0, 0, 1, "R5 irq");
    cyc(0, 1, BASE + 2, 0, 1, "R7 rd");
    cyc(0, 1, BASE + 2, 0, 1, "R7 clr");
    cyc(0, 0, 0, 0, 0, "R6 hold");
    // R5 disabled edge: no irq, status set; R6 write clears irq
    cyc(1, 0, BASE + 2, 8'h00, 0, "R6 clr");
    repeat (4) cyc(0, 0, 0, 0, 1, "R5 dis");
    cyc(0, 1, BASE + 2, 0, 0, "R5 stat");
    // R6/R7 coincidence: edge and ctrl write / read same cycle
    cyc(1, 0, BASE + 2, 8'h08, 0, "R6 arm");
    cyc(0, 0, 0, 0, 1, "R6 e1");
    cyc(0, 0, 0, 0, 1, "R6 e2");
    cyc(1, 0, BASE + 2, 8'h03, 1, "R6 coinc");
    cyc(0, 1, BASE + 2, 0, 1, "R6 post");
    cyc(0, 0, 0, 0, 0, "R7 lo");
    cyc(0, 0, 0, 0, 1, "R7 e1");
    cyc(0, 0, 0, 0, 1, "R7 e2");
    cyc(0, 1, BASE + 2, 0, 1, "R7 coinc");
    cyc(0, 1, BASE + 2, 0, 1, "R7 kept");
    // random phase
    e = 0;
    for (int i = 0; i < 3000; i++) begin
      int op;
      a = BASE + AW'($urandom_range(0, 5));
      if ($urandom_range(0, 7) == 0) e = ~e;
      op = $urandom_range(0, 2);
      cyc(op == 1, op == 2, a, 8'($urandom), e, "rand");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule